// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a memory-mapped watchdog for a system-on-chip. Software programs an expiry action, picks a timeout from a 4-bit code and turns the counter on. From then on it must keep writing a fixed restart pattern to the control register before the timeout runs out. If it stops doing so, the counter reaches zero. When the whole-system-reset action is selected, the block then drives a reset pulse of fixed length.

Writes to the configuration and mode registers carry a 16-bit key in their upper half. The block drops any such write whose key is wrong, so a stray store cannot turn the watchdog off or lengthen its timeout.

Time is counted in ticks. A prescaler divides the clock by `TICK_DIV`, and one tick stands for half a second: `TICK_DIV` is half a second of clock cycles in silicon and a small number in simulation.

Top module: `kwdt_top`

## Requirements
- R1: After reset the watchdog is disabled, `sys_rst_o` is low, and all three registers read as zero.
- R2: The register offsets are control 0x10, configuration 0x14 and mode 0x18. Configuration bits 1:0 hold the action. Mode bit 0 is the enable and bits 7:4 are the timeout code. A read returns the stored fields with every other bit zero. The control register and any unmapped offset read as zero.
- R3: A write to configuration or mode takes effect only if bits 31:16 equal 0x16AA. Otherwise the register and the counter are left unchanged.
- R4: While enabled, a control write whose bits 12:0 equal 0x14AF reloads the counter from the current code. This means bit 0 is 1 and bits 12:1 are 0xA57. Any other control value, or any control write while disabled, has no effect.
- R5: The timeout in ticks is as follows. Code 0 gives 1 tick. Codes 1 to 7 give 2 ticks per unit of the code. Codes 8, 9, 0xA and 0xB give 20, 24, 28 and 32 ticks. A tick is `TICK_DIV` clock cycles. Expiry falls exactly timeout × `TICK_DIV` cycles after the clock edge that loaded the counter.
- R6: Codes 0xC to 0xF give the longest timeout, 32 ticks.
- R7: A keyed mode write reloads the counter in two cases: it sets the enable while the watchdog is off, or it changes the code while the watchdog is on. A keyed write that keeps enable and code as they are does not reload.
- R8: A keyed mode write with bit 0 clear disables the watchdog. The counter then stops, any expired state is cleared, and no reset follows.
- R9: At expiry with action 01, `sys_rst_o` goes high one cycle after the expiry edge and stays high for exactly `PULSE_LEN` cycles.
- R10: At expiry with action 00, 10 or 11, `sys_rst_o` stays low.
- R11: After expiry the counter stays expired and gives no further pulse until a restart or a disable. A restart then re-arms it for a new timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | ADDR_W | Register byte offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the register at `addr` (combinational) |
| sys_rst_o | output | 1 | Active-high system reset pulse |

## Verification
On every cycle, assertions check four things:
- a key-less mode write leaves enable and code untouched;
- the counter never climbs except on a load;
- the expired state holds until a load or a stop, and a disabled watchdog is never expired;
- each reset pulse follows an expiry with the reset action selected and lasts exactly `PULSE_LEN` cycles.

Only the bench's scenarios can show the following:
- the exact timeout for each code, including the clamped codes;
- that correct restarts keep the system alive while wrong patterns and wrong keys do not;
- that changing the code mid-count reloads the counter;
- that the non-reset actions stay silent.

The bench covers these with a per-cycle reference model of remaining cycles, compared against the output and the readback.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

   localparam logic [15:0] WR_KEY      = 16'h16AA;
   localparam logic [12:0] RESTART_PAT = 13'h14AF;
   localparam logic [7:0]  OFS_CTRL    = 8'h10;
   localparam logic [7:0]  OFS_CFG     = 8'h14;
   localparam logic [7:0]  OFS_MODE    = 8'h18;
   localparam int          TICKS_W     = 6;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'b00,
      ACT_SYSRST = 2'b01,
      ACT_RSV2   = 2'b10,
      ACT_RSV3   = 2'b11
   } act_e;

   // timeout code -> half-second ticks
   function automatic logic [TICKS_W-1:0] code_ticks(input logic [3:0] c);
      logic [TICKS_W-1:0] t;
      case (c)
         4'h0:                         t = TICKS_W'(1);
         4'h1, 4'h2, 4'h3, 4'h4,
         4'h5, 4'h6, 4'h7:             t = TICKS_W'({c, 1'b0});
         4'h8:                         t = TICKS_W'(20);
         4'h9:                         t = TICKS_W'(24);
         4'hA:                         t = TICKS_W'(28);
         default:                      t = TICKS_W'(32);
      endcase
      return t;
   endfunction

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
   import kwdt_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [31:0]          wdata,
   output logic [31:0]          rdata,
   output logic                 en_q,
   output act_e                 act_q,
   output logic                 load,
   output logic                 stop,
   output logic [TICKS_W-1:0]   load_ticks
);

   logic [3:0] code_q;
   logic       sel_ctrl, sel_cfg, sel_mode, key_ok;
   logic       mode_wr, cfg_wr, restart_ok;
   logic       new_en;
   logic [3:0] new_code;

   assign sel_ctrl   = (addr == ADDR_W'(OFS_CTRL));
   assign sel_cfg    = (addr == ADDR_W'(OFS_CFG));
   assign sel_mode   = (addr == ADDR_W'(OFS_MODE));
   assign key_ok     = (wdata[31:16] == WR_KEY);
   assign mode_wr    = wr_en && sel_mode && key_ok;
   assign cfg_wr     = wr_en && sel_cfg && key_ok;
   assign restart_ok = wr_en && sel_ctrl && (wdata[12:0] == RESTART_PAT);
   assign new_en     = wdata[0];
   assign new_code   = wdata[7:4];

   assign load = (mode_wr && new_en && (!en_q || (new_code != code_q)))
              || (restart_ok && en_q);
   assign stop = mode_wr && !new_en;
   assign load_ticks = code_ticks(mode_wr ? new_code : code_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         code_q <= 4'h0;
         act_q  <= ACT_NONE;
      end else begin
         if (mode_wr) begin
            en_q   <= new_en;
            code_q <= new_code;
         end
         if (cfg_wr) begin
            act_q <= act_e'(wdata[1:0]);
         end
      end
   end

   always_comb begin
      rdata = 32'h0;
      if (sel_cfg)  rdata[1:0] = act_q;
      if (sel_mode) rdata[7:0] = {code_q, 3'b000, en_q};
   end

   // R3
   bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel_mode && !key_ok) |=> ($stable(en_q) && $stable(code_q)));

endmodule

// File: rtl/kwdt_tick.sv
module kwdt_tick #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic tick
);

   generate
      if (DIV == 1) begin : g_pass
         assign tick = run && !clr;
      end else begin : g_div
         localparam int PW = $clog2(DIV);
         logic [PW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       cnt_q <= '0;
            else if (clr || !run)             cnt_q <= '0;
            else if (cnt_q == PW'(DIV - 1))   cnt_q <= '0;
            else                              cnt_q <= cnt_q + 1'b1;
         end

         assign tick = run && !clr && (cnt_q == PW'(DIV - 1));

         // R5
         tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/kwdt_count.sv
module kwdt_count
   import kwdt_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               load,
   input  logic               stop,
   input  logic [TICKS_W-1:0] load_val,
   input  logic               tick,
   output logic               expired
);

   logic [TICKS_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         expired <= 1'b0;
      end else if (load) begin
         cnt_q   <= load_val;
         expired <= 1'b0;
      end else if (stop || !en) begin
         expired <= 1'b0;
      end else if (tick && !expired) begin
         if (cnt_q <= TICKS_W'(1)) begin
            cnt_q   <= '0;
            expired <= 1'b1;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   // R11
   exp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && en && !load && !stop) |=> expired);

   // R5
   no_climb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
   parameter int LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expired,
   input  logic arm,
   output logic pulse_o
);

   localparam int CW = $clog2(LEN + 1);

   logic [CW-1:0] pcnt_q;
   logic          exp_d;
   logic          fire;

   assign fire = expired && !exp_d && arm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt_q <= '0;
         exp_d  <= 1'b0;
      end else begin
         exp_d <= expired;
         if (pcnt_q != '0)  pcnt_q <= pcnt_q - 1'b1;
         else if (fire)     pcnt_q <= CW'(LEN);
      end
   end

   assign pulse_o = (pcnt_q != '0);

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
   import kwdt_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int TICK_DIV  = 25_000_000,
   parameter int PULSE_LEN = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              sys_rst_o
);

   if (ADDR_W < 5)     $error("ADDR_W too small for register offsets");
   if (TICK_DIV < 1)   $error("TICK_DIV must be at least 1");
   if (PULSE_LEN < 1)  $error("PULSE_LEN must be at least 1");

   logic               en_q, load, stop, tick, expired;
   act_e               act_q;
   logic [TICKS_W-1:0] load_ticks;

   kwdt_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .addr       (addr),
      .wdata      (wdata),
      .rdata      (rdata),
      .en_q       (en_q),
      .act_q      (act_q),
      .load       (load),
      .stop       (stop),
      .load_ticks (load_ticks)
   );

   kwdt_tick #(.DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (en_q),
      .clr   (load || stop),
      .tick  (tick)
   );

   kwdt_count u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_q),
      .load     (load),
      .stop     (stop),
      .load_val (load_ticks),
      .tick     (tick),
      .expired  (expired)
   );

   kwdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .expired (expired),
      .arm     (act_q == ACT_SYSRST),
      .pulse_o (sys_rst_o)
   );

   logic [31:0] hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          hi_cnt <= '0;
      else if (sys_rst_o)  hi_cnt <= hi_cnt + 1'b1;
      else                 hi_cnt <= '0;
   end

   // R9
   rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst_o) |-> ($past(expired) && ($past(act_q) == ACT_SYSRST)));

   // R9
   pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_rst_o) |-> (hi_cnt == 32'(PULSE_LEN)));

   // R8
   idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !expired);

endmodule

// File: tb/kwdt_top_tb.sv
module kwdt_top_tb;

   localparam int TB_DIV = 4;
   localparam int PLEN   = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [31:0] wdata = 32'h0;
   logic [31:0] rdata;
   logic        sys_rst_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int rst_hi_total = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   kwdt_top #(.ADDR_W(8), .TICK_DIV(TB_DIV), .PULSE_LEN(PLEN)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .sys_rst_o(sys_rst_o)
   );

   // reference model: remaining cycles until expiry
   int m_en = 0, m_code = 0, m_act = 0;
   int m_exp = 0, m_expd = 0, m_remain = 0, m_pulse = 0;

   function automatic int half_secs(int c);
      if (c == 0) return 1;
      if (c <= 7) return 2 * c;
      if (c <= 11) return 2 * (10 + 2 * (c - 8));
      return 32;
   endfunction

   function automatic logic [31:0] model_read(logic [7:0] a);
      if (a == 8'h14) return 32'(m_act);
      if (a == 8'h18) return 32'((m_code << 4) | m_en);
      return 32'h0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_code = 0; m_act = 0; m_exp = 0; m_expd = 0;
         m_remain = 0; m_pulse = 0;
      end else begin
         int ld, st, nen, ncode, old_en;
         ld = 0; st = 0; old_en = m_en; nen = m_en; ncode = m_code;
         if (m_pulse > 0) m_pulse--;
         else if (m_exp == 1 && m_expd == 0 && m_act == 1) m_pulse = PLEN;
         m_expd = m_exp;
         if (wr_en && addr == 8'h14 && wdata[31:16] == 16'h16AA)
            m_act = int'(wdata[1:0]);
         if (wr_en && addr == 8'h18 && wdata[31:16] == 16'h16AA) begin
            nen = int'(wdata[0]);
            ncode = int'(wdata[7:4]);
            if (nen == 1 && (m_en == 0 || ncode != m_code)) ld = 1;
            if (nen == 0) st = 1;
         end
         if (wr_en && addr == 8'h10 && wdata[12:0] == 13'h14AF && m_en == 1) ld = 1;
         if (ld == 1) begin
            m_remain = half_secs(ncode) * TB_DIV;
            m_exp = 0;
         end else if (st == 1 || old_en == 0) begin
            m_exp = 0;
         end else if (m_exp == 0) begin
            m_remain--;
            if (m_remain == 0) m_exp = 1;
         end
         m_en = nen;
         m_code = ncode;
      end
   end

   // per-cycle comparison away from the clock edge
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         cycles++;
         if (sys_rst_o) rst_hi_total++;
         checks++;
         if (sys_rst_o !== (m_pulse > 0)) begin
            errors++;
            $display("FAIL %s: sys_rst_o actual=%0b expected=%0b at cycle %0d",
                     cur_req, sys_rst_o, (m_pulse > 0), cycles);
         end
         checks++;
         if (rdata !== model_read(addr)) begin
            errors++;
            $display("FAIL %s: rdata@%h actual=%h expected=%h",
                     cur_req, addr, rdata, model_read(addr));
         end
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = 32'h0;
   endtask

   task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
      @(negedge clk);
      addr = a;
      #3;
      check(req, rdata, exp);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      finish_run();
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      cur_req = "R1";
      rd("R1", 8'h10, 32'h0);
      rd("R1", 8'h14, 32'h0);
      rd("R1", 8'h18, 32'h0);
      check("R1", {31'h0, sys_rst_o}, 32'h0);

      // R3: wrong keys are ignored
      cur_req = "R3";
      wr(8'h18, 32'h16AB_0051);
      wr(8'h14, 32'h0000_0001);
      rd("R3", 8'h18, 32'h0);
      rd("R3", 8'h14, 32'h0);

      // R2: keyed writes read back fields only
      cur_req = "R2";
      wr(8'h14, 32'h16AA_FFFD);
      rd("R2", 8'h14, 32'h1);
      rd("R2", 8'h10, 32'h0);
      rd("R2", 8'h0C, 32'h0);

      // R4: restart while disabled has no effect
      cur_req = "R4";
      base = rst_hi_total;
      wr(8'h10, 32'h0000_14AF);
      idle(40);
      check("R4", 32'(rst_hi_total - base), 32'h0);

      // R9/R5: code 1 -> 8 cycles, pulse of PLEN
      cur_req = "R9";
      base = rst_hi_total;
      wr(8'h18, 32'h16AA_0011);
      rd("R2", 8'h18, 32'h11);
      idle(40);
      check("R9", 32'(rst_hi_total - base), 32'(PLEN));

      // R11: stays expired, no second pulse
      cur_req = "R11";
      base = rst_hi_total;
      idle(60);
      check("R11", 32'(rst_hi_total - base), 32'h0);
      wr(8'h10, 32'h0000_14AF);
      idle(40);
      check("R11", 32'(rst_hi_total - base), 32'(PLEN));

      // R4: keep-alive with code 2 (16 cycles) and wrong patterns
      cur_req = "R4";
      wr(8'h18, 32'h16AA_0021);
      base = rst_hi_total;
      for (int i = 0; i < 8; i++) begin
         wr(8'h10, 32'hFFFF_E000 | 32'h14AF);
         idle(8);
      end
      check("R4", 32'(rst_hi_total - base), 32'h0);
      wr(8'h10, 32'h0000_14AE);
      wr(8'h10, 32'h0000_0A57);
      idle(40);
      check("R4", 32'(rst_hi_total - base), 32'(PLEN));

      // R7: same code does not reload; code change does
      cur_req = "R7";
      wr(8'h10, 32'h0000_14AF);
      idle(6);
      wr(8'h18, 32'h16AA_0021);
      idle(4);
      wr(8'h18, 32'h16AA_0031);
      idle(40);

      // R8: disable mid-count
      cur_req = "R8";
      wr(8'h10, 32'h0000_14AF);
      idle(5);
      base = rst_hi_total;
      wr(8'h18, 32'h16AA_0000);
      idle(80);
      check("R8", 32'(rst_hi_total - base), 32'h0);
      rd("R8", 8'h18, 32'h0);

      // R10: non-reset actions
      cur_req = "R10";
      base = rst_hi_total;
      wr(8'h14, 32'h16AA_0002);
      wr(8'h18, 32'h16AA_0001);
      idle(20);
      wr(8'h14, 32'h16AA_0003);
      wr(8'h10, 32'h0000_14AF);
      idle(20);
      wr(8'h14, 32'h16AA_0000);
      wr(8'h10, 32'h0000_14AF);
      idle(20);
      check("R10", 32'(rst_hi_total - base), 32'h0);
      wr(8'h18, 32'h16AA_0000);

      // R5: code 0, 8, 0xB timing via the model
      cur_req = "R5";
      wr(8'h14, 32'h16AA_0001);
      wr(8'h18, 32'h16AA_0001);
      idle(30);
      wr(8'h18, 32'h16AA_0000);
      wr(8'h18, 32'h16AA_0081);
      idle(100);
      wr(8'h18, 32'h16AA_00B1);
      idle(150);

      // R6: code 0xF clamps to 32 ticks
      cur_req = "R6";
      base = rst_hi_total;
      wr(8'h18, 32'h16AA_00F1);
      idle(120);
      check("R6", 32'(rst_hi_total - base), 32'h0);
      idle(40);
      check("R6", 32'(rst_hi_total - base), 32'(PLEN));

      finish_run();
   end

endmodule